// File: doc/BRIEF.md
# Skip-Conditional Program Counter Sequencer

This block holds the program counter of a small word-oriented processor and decides its next value once per executed instruction. Conditional control flow is done without branch offsets: an instruction may ask to skip the instruction that follows it. The skip depends on the ALU result (negative or zero) or on an input-ready flag. An unconditional jump loads the low bits of the ALU result into the counter. The counter is 10 bits wide, and all address arithmetic wraps modulo 1024.

Every cycle, a small decision stage sorts the cycle into one of four named actions. ACT_STAY is taken under reset-free hold, or when no instruction executes. ACT_STEP means advance by one. ACT_SKIP means advance by two. ACT_JUMP means load the target. The priority is: hold, then no enable, then jump, then the skip test. The counter register then commits the chosen next address. A link address, equal to the counter plus one, is always presented so that a jump can write back its return address.

The transitions are:
- STAY→hold: hold is high.
- STAY→idle: enable is low.
- JUMP: enable is high and jump is requested.
- SKIP: enable is high and the skip test passes.
- STEP: every other enabled cycle.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets pc_q to 0 at that edge.
- R2: With step_en low and hold low, pc_q keeps its value whatever jump_req, skip_sel, alu_val and in_ready are.
- R3: With hold high, pc_q keeps its value even when step_en and jump_req are high.
- R4: With skip_sel = 0, an enabled cycle without jump advances pc_q by exactly 1, whatever alu_val and in_ready are.
- R5: With skip_sel = 1, an enabled cycle without jump advances pc_q by 2 when alu_val bit 31 is 1 (negative as a signed 32-bit value), else by 1.
- R6: With skip_sel = 2, an enabled cycle without jump advances pc_q by 2 when alu_val equals zero, else by 1.
- R7: With skip_sel = 3, an enabled cycle without jump advances pc_q by 2 when in_ready is high, else by 1.
- R8: An enabled cycle with jump_req high loads pc_q with alu_val[9:0], regardless of skip_sel.
- R9: link_addr always equals pc_q + 1 modulo 1024, without delay.
- R10: All counter arithmetic wraps modulo 1024 (1023+1 gives 0, 1022+2 gives 0, 1023+2 gives 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | An instruction executes this cycle |
| hold | input | 1 | Freeze the counter |
| skip_sel | input | 2 | Skip condition: 0 never, 1 negative, 2 zero, 3 input ready |
| alu_val | input | 32 | ALU result of the executing instruction |
| in_ready | input | 1 | Input-ready flag for skip condition 3 |
| jump_req | input | 1 | Executing instruction is a jump |
| pc_q | output | 10 | Current program counter |
| link_addr | output | 10 | pc_q + 1, return address for a jump |

## Verification
The assertions assume that rst is high at the first rising edge, so that pc_q is defined before any clocked property compares it with its past value. They also assume that every control input is a known 0 or 1 at each edge. The bench holds rst from time zero through the first edges. It changes all inputs only on falling edges and never leaves an input undriven, so every edge sees settled, known values.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        SK_NEVER = 2'd0,
        SK_NEG   = 2'd1,
        SK_ZERO  = 2'd2,
        SK_READY = 2'd3
    } skip_code_e;

    typedef enum logic [1:0] {
        ACT_STAY = 2'd0,
        ACT_STEP = 2'd1,
        ACT_SKIP = 2'd2,
        ACT_JUMP = 2'd3
    } pc_action_e;

endpackage

// File: rtl/pcs_skip_eval.sv
module pcs_skip_eval
    import pcs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  skip_code_e          skip_code,
    input  logic [DATA_W-1:0]   alu_val,
    input  logic                in_ready,
    output logic                take_skip
);

    localparam int SIGN_BIT = DATA_W - 1;

    logic is_neg;
    logic is_zero;

    assign is_neg  = alu_val[SIGN_BIT];
    assign is_zero = (alu_val == '0);

    always_comb begin
        unique case (skip_code)
            SK_NEVER: take_skip = 1'b0;
            SK_NEG:   take_skip = is_neg;
            SK_ZERO:  take_skip = is_zero;
            SK_READY: take_skip = in_ready;
            default:  take_skip = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcs_action_sel.sv
module pcs_action_sel
    import pcs_pkg::*;
(
    input  logic       step_en,
    input  logic       hold,
    input  logic       jump_req,
    input  logic       take_skip,
    output pc_action_e action
);

    always_comb begin
        if (hold || !step_en) begin
            action = ACT_STAY;
        end else if (jump_req) begin
            action = ACT_JUMP;
        end else if (take_skip) begin
            action = ACT_SKIP;
        end else begin
            action = ACT_STEP;
        end
    end

endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
    import pcs_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int DATA_W = 32
) (
    input  logic [PC_W-1:0]   pc_cur,
    input  pc_action_e        action,
    input  logic [DATA_W-1:0] alu_val,
    output logic [PC_W-1:0]   pc_next,
    output logic [PC_W-1:0]   pc_plus1
);

    localparam logic [PC_W-1:0] ONE = PC_W'(1);
    localparam logic [PC_W-1:0] TWO = PC_W'(2);

    logic [PC_W-1:0] pc_plus2;
    logic [PC_W-1:0] jump_tgt;

    assign pc_plus1 = pc_cur + ONE;
    assign pc_plus2 = pc_cur + TWO;
    assign jump_tgt = alu_val[PC_W-1:0];

    always_comb begin
        unique case (action)
            ACT_STAY: pc_next = pc_cur;
            ACT_STEP: pc_next = pc_plus1;
            ACT_SKIP: pc_next = pc_plus2;
            ACT_JUMP: pc_next = jump_tgt;
            default:  pc_next = pc_cur;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int PC_W   = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              hold,
    input  logic [1:0]        skip_sel,
    input  logic [DATA_W-1:0] alu_val,
    input  logic              in_ready,
    input  logic              jump_req,
    output logic [PC_W-1:0]   pc_q,
    output logic [PC_W-1:0]   link_addr
);

    localparam logic [PC_W-1:0] PC_RESET = '0;

    skip_code_e      skip_code;
    logic            take_skip;
    pc_action_e      action;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] pc_reg;

    assign skip_code = skip_code_e'(skip_sel);

    pcs_skip_eval #(.DATA_W(DATA_W)) u_skip (
        .skip_code (skip_code),
        .alu_val   (alu_val),
        .in_ready  (in_ready),
        .take_skip (take_skip)
    );

    pcs_action_sel u_act (
        .step_en   (step_en),
        .hold      (hold),
        .jump_req  (jump_req),
        .take_skip (take_skip),
        .action    (action)
    );

    pcs_next_addr #(.PC_W(PC_W), .DATA_W(DATA_W)) u_next (
        .pc_cur   (pc_reg),
        .action   (action),
        .alu_val  (alu_val),
        .pc_next  (pc_next),
        .pc_plus1 (link_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_reg <= PC_RESET;
        end else begin
            pc_reg <= pc_next;
        end
    end

    // Outputs
    always_comb begin
        pc_q = pc_reg;
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pc_q == PC_RESET));

    // R2
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !hold) |=> $stable(pc_q));

    // R3
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pc_q));

    // R4
    p_never_skip_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !hold && !jump_req && skip_sel == 2'd0)
        |=> (pc_q == PC_W'($past(pc_q) + PC_W'(1))));

    // R5, R6, R7: an enabled non-jump cycle moves the counter by 1 or 2
    p_step_delta_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && !hold && !jump_req)
        |=> (PC_W'(pc_q - $past(pc_q)) == PC_W'(1) ||
             PC_W'(pc_q - $past(pc_q)) == PC_W'(2)));

    // R8
    p_jump_load_r8: assert property (@(posedge clk) disable iff (rst)
        (step_en && !hold && jump_req)
        |=> (pc_q == $past(alu_val[PC_W-1:0])));

endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic        hold = 1'b0;
    logic [1:0]  skip_sel = 2'd0;
    logic [31:0] alu_val = '0;
    logic        in_ready = 1'b0;
    logic        jump_req = 1'b0;
    logic [9:0]  pc_q;
    logic [9:0]  link_addr;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer u_dut (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .hold      (hold),
        .skip_sel  (skip_sel),
        .alu_val   (alu_val),
        .in_ready  (in_ready),
        .jump_req  (jump_req),
        .pc_q      (pc_q),
        .link_addr (link_addr)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive on falling edge, clock once, sample 1 time unit after the rising edge
    task automatic cyc(input logic en, input logic hd, input logic jp,
                       input logic [1:0] sk, input logic [31:0] alu, input logic rdy);
        @(negedge clk);
        step_en = en; hold = hd; jump_req = jp;
        skip_sel = sk; alu_val = alu; in_ready = rdy;
        @(posedge clk);
        #1;
    endtask

    task automatic go_to(input logic [9:0] addr);
        cyc(1'b1, 1'b0, 1'b1, 2'd0, {22'h0, addr}, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset", pc_q, 10'd0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_never;
        go_to(10'd100);
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h8000_0000, 1'b1);
        check("R4 never skip neg/ready", pc_q, 10'd101);
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
        check("R4 never skip zero", pc_q, 10'd102);
    endtask

    task automatic t_neg;
        go_to(10'd200);
        cyc(1'b1, 1'b0, 1'b0, 2'd1, 32'h8000_0000, 1'b0);
        check("R5 negative skips", pc_q, 10'd202);
        cyc(1'b1, 1'b0, 1'b0, 2'd1, 32'h7FFF_FFFF, 1'b1);
        check("R5 positive steps", pc_q, 10'd203);
        cyc(1'b1, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0);
        check("R5 zero steps", pc_q, 10'd204);
    endtask

    task automatic t_zero;
        go_to(10'd300);
        cyc(1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0);
        check("R6 zero skips", pc_q, 10'd302);
        cyc(1'b1, 1'b0, 1'b0, 2'd2, 32'hFFFF_FFFF, 1'b1);
        check("R6 nonzero steps", pc_q, 10'd303);
    endtask

    task automatic t_ready;
        go_to(10'd400);
        cyc(1'b1, 1'b0, 1'b0, 2'd3, 32'h5, 1'b1);
        check("R7 ready skips", pc_q, 10'd402);
        cyc(1'b1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0);
        check("R7 not ready steps", pc_q, 10'd403);
    endtask

    task automatic t_jump;
        cyc(1'b1, 1'b0, 1'b1, 2'd2, 32'hFFFF_F155, 1'b1);
        check("R8 jump low bits", pc_q, 10'h155);
        cyc(1'b1, 1'b0, 1'b1, 2'd3, 32'h0000_0007, 1'b1);
        check("R8 jump ignores skip", pc_q, 10'd7);
    endtask

    task automatic t_hold_idle;
        go_to(10'd500);
        cyc(1'b1, 1'b1, 1'b1, 2'd2, 32'h0, 1'b1);
        check("R3 hold with jump", pc_q, 10'd500);
        cyc(1'b1, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
        check("R3 hold with step", pc_q, 10'd500);
        cyc(1'b0, 1'b0, 1'b1, 2'd3, 32'h11, 1'b1);
        check("R2 idle ignores jump", pc_q, 10'd500);
        cyc(1'b0, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0);
        check("R2 idle ignores skip", pc_q, 10'd500);
    endtask

    task automatic t_link;
        go_to(10'd341);
        check("R9 link after jump", link_addr, 10'd342);
        cyc(1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0);
        check("R9 link after skip", link_addr, 10'd344);
        go_to(10'd1023);
        check("R9 link wraps", link_addr, 10'd0);
    endtask

    task automatic t_wrap;
        go_to(10'd1023);
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h1, 1'b0);
        check("R10 1023+1", pc_q, 10'd0);
        go_to(10'd1022);
        cyc(1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0);
        check("R10 1022+2", pc_q, 10'd0);
        go_to(10'd1023);
        cyc(1'b1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b1);
        check("R10 1023+2", pc_q, 10'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 initial reset", pc_q, 10'd0);
        @(negedge clk); rst = 1'b0;
        t_never();
        t_neg();
        t_zero();
        t_ready();
        t_jump();
        t_hold_idle();
        t_link();
        t_wrap();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule